// File: doc/BRIEF.md
# Serial Interrupt Host Deserializer

This block is the host end of a single shared open-drain interrupt wire on a low-pin-count peripheral bus. It frames the wire: it pulls it low for a start frame, then divides the time that follows into seventeen three-clock slots. In each slot one peripheral may pull the wire low to signal that its interrupt is active. The block then ends the frame with a stop pulse. The level seen in each slot is kept as a request bit, so downstream masking and status logic sees a set of level-sensitive interrupts.

A 32-bit control word configures the block. It carries an enable, a choice between continuous framing and quiet framing, and the start-pulse width. In continuous mode the host begins every frame on its own. In quiet mode the host stays silent until a peripheral pulls the wire low for one clock, and then drives the rest of the start pulse. Slots 2 and 16 usually carry the system-management and channel-check indications, and they are reported like any other slot.

Top module: `serirq_host`

## Requirements
- R1: While ctrl_i[31] is 0 the block never asserts serirq_oe_o and irq_o reads all zero one clock after the bit clears, whatever level the wire has.
- R2: In continuous mode (ctrl_i[30]=0) a frame is: start pulse, 2 released clocks, 17 slots of 3 clocks each, stop pulse, 2 released clocks and 1 idle clock, after which the next start pulse begins without any wire activity.
- R3: ctrl_i[25:24] sets the start-pulse width: 00 gives 4 clocks, 01 gives 6, 10 gives 8, and 11 is treated as 4.
- R4: In quiet mode (ctrl_i[30]=1) the host does not drive while the wire stays high. One clock of low driven by a peripheral while idle makes the host drive the start pulse for the selected width minus one further clocks.
- R5: Slot n (0 to 16) is sampled in its first clock. A low level sets irq_o[31-n] to 1 and a high level sets it to 0. irq_o[14:0] is always 0.
- R6: The stop pulse is 2 clocks in quiet mode and 3 clocks in continuous mode. Two released clocks follow it, and then the block is idle.
- R7: Each irq_o bit keeps its value from one frame into the next until its own slot is sampled again.
- R8: The wire is only ever pulled low or released. serirq_oe_o=1 means pull low, and the block has no way to drive the wire high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Control: [31] enable, [30] quiet mode, [25:24] start width code |
| serirq_i | input | 1 | Level observed on the shared wire |
| serirq_oe_o | output | 1 | 1 pulls the wire low, 0 releases it |
| irq_o | output | 32 | Active requests, slot n on bit 31-n, bits 14:0 zero |

## Verification
The hardest situation to reach from the ports is the hold between frames. It only shows when a bit set in one frame is still visible at the start of the next frame, before its slot comes round again, and is then cleared by that slot. The bench models the peripheral side of the wire. It tracks the host's drive enable to locate slot boundaries itself, then runs back-to-back continuous frames with different slot patterns and checks irq_o against the previous frame's pattern just before slot 0 of the new frame. A quiet-mode start also needs the peripheral to pull the wire low while the host is idle, and the bench injects that one-clock pulse and then measures the remaining start width.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_START_REC,
    ST_SLOT,
    ST_STOP,
    ST_STOP_REC
  } frame_st_e;

  function automatic logic [3:0] start_clks(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd6;
      2'b10:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/serirq_frame_fsm.sv
module serirq_frame_fsm
  import serirq_pkg::*;
#(
  parameter int NSLOT     = 17,
  parameter int SLOT_CLKS = 3,
  parameter int REC_CLKS  = 2,
  localparam int SLOT_W   = $clog2(NSLOT),
  localparam int PH_W     = $clog2(SLOT_CLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              quiet_i,
  input  logic [1:0]        width_code_i,
  input  logic              line_i,
  output logic              drive_low_o,
  output logic              sample_o,
  output logic [SLOT_W-1:0] slot_o
);
  frame_st_e         state_q;
  logic [3:0]        cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PH_W-1:0]   phase_q;
  logic [3:0]        width;

  assign width = start_clks(width_code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      phase_q <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      phase_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!quiet_i) begin
            state_q <= ST_START;
            cnt_q   <= width - 4'd1;
          end else if (!line_i) begin
            // peripheral already supplied the first low clock
            state_q <= ST_START;
            cnt_q   <= width - 4'd2;
          end
        end
        ST_START: begin
          if (cnt_q == '0) begin
            state_q <= ST_START_REC;
            cnt_q   <= 4'(REC_CLKS - 1);
          end else cnt_q <= cnt_q - 4'd1;
        end
        ST_START_REC: begin
          if (cnt_q == '0) begin
            state_q <= ST_SLOT;
            slot_q  <= '0;
            phase_q <= '0;
          end else cnt_q <= cnt_q - 4'd1;
        end
        ST_SLOT: begin
          if (phase_q == PH_W'(SLOT_CLKS - 1)) begin
            phase_q <= '0;
            if (slot_q == SLOT_W'(NSLOT - 1)) begin
              state_q <= ST_STOP;
              cnt_q   <= quiet_i ? 4'd1 : 4'd2;
            end else slot_q <= slot_q + 1'b1;
          end else phase_q <= phase_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == '0) begin
            state_q <= ST_STOP_REC;
            cnt_q   <= 4'(REC_CLKS - 1);
          end else cnt_q <= cnt_q - 4'd1;
        end
        ST_STOP_REC: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else cnt_q <= cnt_q - 4'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_low_o = en_i && (state_q == ST_START || state_q == ST_STOP);
  assign sample_o    = en_i && state_q == ST_SLOT && phase_q == '0;
  assign slot_o      = slot_q;

  a_r1_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));
  a_r2_slot_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLOT) |-> (slot_q < SLOT_W'(NSLOT) && phase_q < PH_W'(SLOT_CLKS)));
  a_r4_quiet_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && en_i && quiet_i && line_i) |=> (state_q == ST_IDLE));
  a_r6_stop_to_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && cnt_q == '0 && en_i) |=> (state_q == ST_STOP_REC));
endmodule

// File: rtl/serirq_slot_capture.sv
module serirq_slot_capture #(
  parameter int NSLOT   = 17,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sample_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              line_i,
  output logic [NSLOT-1:0]  act_o
);
  logic [NSLOT-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  act_q <= '0;
    else if (!en_i)                               act_q <= '0;
    else if (sample_i && slot_i < SLOT_W'(NSLOT)) act_q[slot_i] <= ~line_i;
  end

  assign act_o = act_q;

  a_r5_sample_low_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && en_i && slot_i < SLOT_W'(NSLOT)) |=> (act_q[$past(slot_i)] == !$past(line_i)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && en_i) |=> $stable(act_q));
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (act_q == '0));
endmodule

// File: rtl/serirq_host.sv
module serirq_host #(
  parameter int NSLOT   = 17,
  parameter int VEC_W   = 32,
  parameter int EN_BIT  = 31,
  parameter int QM_BIT  = 30,
  parameter int WID_LSB = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ctrl_i,
  input  logic        serirq_i,
  output logic        serirq_oe_o,
  output logic [31:0] irq_o
);
  localparam int SLOT_W = $clog2(NSLOT);

  logic              en, quiet, sample;
  logic [1:0]        wcode;
  logic [SLOT_W-1:0] slot;
  logic [NSLOT-1:0]  act;

  assign en    = ctrl_i[EN_BIT];
  assign quiet = ctrl_i[QM_BIT];
  assign wcode = ctrl_i[WID_LSB+:2];

  serirq_frame_fsm #(.NSLOT(NSLOT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .quiet_i     (quiet),
    .width_code_i(wcode),
    .line_i      (serirq_i),
    .drive_low_o (serirq_oe_o),
    .sample_o    (sample),
    .slot_o      (slot)
  );

  serirq_slot_capture #(.NSLOT(NSLOT)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .sample_i(sample),
    .slot_i  (slot),
    .line_i  (serirq_i),
    .act_o   (act)
  );

  // slot n lands on bit VEC_W-1-n, remaining low bits stay zero
  for (genvar b = 0; b < VEC_W; b++) begin : g_map
    if (b >= VEC_W - NSLOT) begin : g_slot
      assign irq_o[b] = act[VEC_W-1-b];
    end else begin : g_zero
      assign irq_o[b] = 1'b0;
    end
  end

  a_r8_oe_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !serirq_oe_o);
endmodule

// File: tb/sim_serirq_host.sv
module sim_serirq_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        pull = 1'b0;
  logic        oe;
  logic [31:0] irq;
  logic        line;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] prev_exp = '0;
  event stop_seen;

  always #5 clk = ~clk;
  assign line = ~(oe | pull);

  serirq_host u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
    .serirq_i(line), .serirq_oe_o(oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] to_vec(input logic [16:0] pat);
    logic [31:0] v = '0;
    for (int n = 0; n < 17; n++) v[31-n] = pat[n];
    return v;
  endfunction

  // scoreboard monitor: compare at each stop pulse
  initial forever begin
    @(stop_seen);
    if (exp_q.size() == 0) chk("R5 scoreboard empty", 32'd1, 32'd0);
    else chk("R5 slot vector", irq, exp_q.pop_front());
  end

  // one frame; ctrl must already be set; returns on first negedge after gap
  task automatic frame(input bit quiet, input int w, input logic [16:0] pat);
    int n_on;
    int gap;
    int guard;
    exp_q.push_back(to_vec(pat));
    if (quiet) begin
      @(negedge clk); pull = 1'b1;
      @(negedge clk); pull = 1'b0;
    end else begin
      guard = 0;
      while (!oe && guard < 50) begin @(negedge clk); guard++; end
    end
    n_on = 0;
    while (oe && n_on < 20) begin n_on++; @(negedge clk); end
    if (quiet) chk("R4 quiet start remainder", n_on, w - 1);
    else chk("R3 start width", n_on, w);
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold before slot0", irq, prev_exp);
    for (int n = 0; n < 17; n++) begin
      pull = pat[n];
      @(negedge clk); pull = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    chk("R6 stop begins after slot16", {31'd0, oe}, 32'd1);
    -> stop_seen;
    n_on = 0;
    while (oe && n_on < 10) begin n_on++; @(negedge clk); end
    chk("R6 stop length", n_on, quiet ? 2 : 3);
    gap = 0;
    while (!oe && gap < 12) begin gap++; @(negedge clk); end
    if (quiet) chk("R4 quiet no self start", gap, 12);
    else chk("R2 gap to next start", gap, 3);
    prev_exp = to_vec(pat);
  endtask

  task automatic disable_blk();
    ctrl = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 cleared when disabled", irq, 32'd0);
    prev_exp = '0;
  endtask

  initial begin
    int drove;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", {31'd0, oe}, 32'd0);
    chk("R1 reset irq", irq, 32'd0);
    rst_n = 1'b1;
    // disabled, wire pulled now and then
    drove = 0;
    for (int i = 0; i < 60; i++) begin
      pull = (i % 7 == 0);
      @(negedge clk);
      if (oe) drove++;
    end
    pull = 1'b0;
    chk("R1 no drive when disabled", drove, 0);
    chk("R1 irq zero when disabled", irq, 32'd0);
    // continuous, width 4, back-to-back frames (R2, R7)
    ctrl = 32'h8000_0000;
    frame(1'b0, 4, 17'h1_0005);
    frame(1'b0, 4, 17'h0_0F04);
    disable_blk();
    ctrl = 32'h8100_0000;
    frame(1'b0, 6, 17'h1_FFFF);
    disable_blk();
    ctrl = 32'h8200_0000;
    frame(1'b0, 8, 17'h0_0000);
    disable_blk();
    ctrl = 32'h8300_0000;
    frame(1'b0, 4, 17'h0_AAAA);
    disable_blk();
    // quiet mode
    ctrl = 32'hC000_0000;
    frame(1'b1, 4, 17'h1_0004);
    frame(1'b1, 4, 17'h0_0101);
    disable_blk();
    ctrl = 32'hC200_0000;
    frame(1'b1, 8, 17'h1_5555);
    chk("R5 low bits zero", {17'd0, irq[14:0]}, 32'd0);
    disable_blk();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule